// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block arbitrates sixteen level-sensitive interrupt request lines for one processor. Two identical eight-line priority units do the work. The secondary unit resolves lines 8 to 15 and presents its own request on input 2 of the primary unit, which resolves lines 0 to 7 and drives the single interrupt output. Each unit keeps a mask, a latch of pending requests, an in-service record and a rotating priority pointer.

Software talks to the block over a byte-wide register bus with four addresses: a command/status port and a mask port for each unit. The processor takes an interrupt with a one-cycle acknowledge strobe, and the vector output carries the global line number in that same cycle. After servicing, software writes a specific-level end-of-interrupt command. That command retires the level and moves it to the bottom of its unit's priority order. A secondary line is retired in two steps: first the secondary unit at the line's local level, then the primary unit at level 2.

Top module: `pic_cascade`

## Requirements
- R1: After reset, both mask registers read 0xFF, int_o is low, no level is in service, and each unit ranks level 0 highest and level 7 lowest.
- R2: The primary mask is at address 0x21 and the secondary mask at 0xA1. Both are writable and read back. A 1 in bit L keeps line L from raising an interrupt, but the line's request is still latched.
- R3: A read of 0x20 (primary) or 0xA0 (secondary) returns that unit's latched request bits. Bit 2 of the primary value shows whether the secondary unit is requesting.
- R4: While inta_i is high for one cycle, vector_o carries in that cycle the global number of the winning request. Primary level L gives vector L. A win by the secondary unit's level L, through primary level 2, gives vector 8+L.
- R5: On acknowledge, the winning level is marked in service and its request latch is cleared. A secondary win also marks primary level 2 in service.
- R6: int_o is high only when some unmasked pending request in a unit outranks every in-service level of that unit; equal rank is not enough. While primary level 2 is in service, no secondary line can raise int_o.
- R7: A command write whose data has bits [7:5] = 111 clears the in-service bit of the level in bits [2:0] and makes that level the lowest priority of the unit. A command write with any other top bits changes nothing.
- R8: An acknowledge while int_o is low returns the primary unit's current lowest-priority level as the vector and changes no state.
- R9: A request line held high is latched again in the cycle after its acknowledge. A latched request stays pending after its line falls, until it is acknowledged.
- R10: irq_i[2] has no effect; primary input 2 is used only by the cascade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Level-sensitive request lines, bit n is line n |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| inta_i | input | 1 | Interrupt acknowledge, one-cycle pulse |
| vector_o | output | 8 | Vector, valid while inta_i is high |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the in-RTL assertions check that an end-of-interrupt retires its level and moves the rotation pointer, that an acknowledge sets the in-service bit of the winner, and that the resolver never offers a level that is already in service. They also check that a cascaded acknowledge marks both units, and that a spurious acknowledge leaves the in-service state unchanged. Only the bench scenarios show the following: the rotated order after a run of end-of-interrupts, the vector numbering across the cascade, re-latching of held lines, blocking of secondary lines behind primary level 2, and the fact that irq_i[2] and commands other than end-of-interrupt have no effect.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int          UNIT_N      = 8;
  localparam int          UNIT_LW     = $clog2(UNIT_N);
  localparam int          DW          = 8;
  localparam int          VW          = 8;
  localparam int          CASC_LVL    = 2;
  localparam logic [2:0]  EOI_OP      = 3'b111;
  localparam logic [7:0]  ADDR_M_CMD  = 8'h20;
  localparam logic [7:0]  ADDR_M_MASK = 8'h21;
  localparam logic [7:0]  ADDR_S_CMD  = 8'hA0;
  localparam logic [7:0]  ADDR_S_MASK = 8'hA1;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  input  logic [LW-1:0] low_i,
  output logic          valid_o,
  output logic [LW-1:0] lvl_o
);
  // walk from the highest rank down; an in-service level closes the search
  always_comb begin
    logic          hit_p;
    logic          hit_s;
    logic [LW-1:0] idx;
    hit_p = 1'b0;
    hit_s = 1'b0;
    idx   = '0;
    lvl_o = '0;
    for (int r = 0; r < N; r++) begin
      idx = LW'((int'(low_i) + 1 + r) % N);
      if (isr_i[idx]) hit_s = 1'b1;
      if (!hit_s && !hit_p && pend_i[idx]) begin
        hit_p = 1'b1;
        lvl_o = idx;
      end
    end
    valid_o = hit_p;
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit import pic_pkg::*; #(
  parameter int           N     = UNIT_N,
  parameter int           LW    = $clog2(N),
  parameter logic [N-1:0] LATCH = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          mask_we_i,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  isr_o,
  output logic          valid_o,
  output logic [LW-1:0] lvl_o,
  output logic [LW-1:0] low_o
);
  logic [N-1:0]  mask_q, isr_q, irr_eff, pend, eoi_clr, ack_set;
  logic [LW-1:0] low_q, win_lvl, eoi_lvl;
  logic          win_valid, eoi, take;

  assign eoi     = cmd_we_i && (wdata_i[DW-1 -: 3] == EOI_OP);
  assign eoi_lvl = wdata_i[LW-1:0];
  assign take    = ack_i && win_valid;
  assign eoi_clr = eoi  ? (N'(1) << eoi_lvl) : '0;
  assign ack_set = take ? (N'(1) << win_lvl) : '0;

  for (genvar g = 0; g < N; g++) begin : g_irr
    if (LATCH[g]) begin : g_latch
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q | req_i[g]) & ~ack_set[g];
      end
      assign irr_eff[g] = q;
    end else begin : g_pass
      assign irr_eff[g] = req_i[g];
    end
  end

  assign pend = irr_eff & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      isr_q  <= '0;
      low_q  <= LW'(N - 1);
    end else begin
      if (mask_we_i) mask_q <= wdata_i[N-1:0];
      isr_q <= (isr_q & ~eoi_clr) | ack_set;
      if (eoi) low_q <= eoi_lvl;
    end
  end

  pic_prio #(.N(N), .LW(LW)) i_prio (
    .pend_i (pend),
    .isr_i  (isr_q),
    .low_i  (low_q),
    .valid_o(win_valid),
    .lvl_o  (win_lvl)
  );

  assign mask_o  = mask_q;
  assign irr_o   = irr_eff;
  assign isr_o   = isr_q;
  assign valid_o = win_valid;
  assign lvl_o   = win_lvl;
  assign low_o   = low_q;

  a_r7_eoi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi && !(take && win_lvl == eoi_lvl) |=> !isr_q[$past(eoi_lvl)]);
  a_r7_eoi_rotates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi |=> low_q == $past(eoi_lvl));
  a_r5_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> isr_q[$past(win_lvl)]);
  a_r6_winner_not_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> !isr_q[win_lvl]);
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade import pic_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   irq_i,
  input  logic [7:0]    addr_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          inta_i,
  output logic [7:0]    vector_o,
  output logic          int_o
);
  localparam int N  = UNIT_N;
  localparam int LW = UNIT_LW;
  localparam logic [N-1:0] M_LATCH = ~(N'(1) << CASC_LVL);

  logic [N-1:0]  m_req, m_mask, m_irr, m_isr, s_mask, s_irr, s_isr;
  logic [LW-1:0] m_lvl, m_low, s_lvl, s_low_unused;
  logic          m_valid, s_valid, s_ack, casc_win, unused_casc_in;

  assign unused_casc_in = irq_i[CASC_LVL];

  for (genvar g = 0; g < N; g++) begin : g_mreq
    if (g == CASC_LVL) begin : g_casc
      assign m_req[g] = s_valid;
    end else begin : g_line
      assign m_req[g] = irq_i[g];
    end
  end

  assign casc_win = m_valid && (m_lvl == LW'(CASC_LVL));
  assign s_ack    = inta_i && casc_win;

  pic_unit #(.N(N), .LW(LW), .LATCH(M_LATCH)) i_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (m_req),
    .mask_we_i(wr_i && addr_i == ADDR_M_MASK),
    .cmd_we_i (wr_i && addr_i == ADDR_M_CMD),
    .wdata_i  (wdata_i),
    .ack_i    (inta_i),
    .mask_o   (m_mask),
    .irr_o    (m_irr),
    .isr_o    (m_isr),
    .valid_o  (m_valid),
    .lvl_o    (m_lvl),
    .low_o    (m_low)
  );

  pic_unit #(.N(N), .LW(LW)) i_slave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (irq_i[2*N-1:N]),
    .mask_we_i(wr_i && addr_i == ADDR_S_MASK),
    .cmd_we_i (wr_i && addr_i == ADDR_S_CMD),
    .wdata_i  (wdata_i),
    .ack_i    (s_ack),
    .mask_o   (s_mask),
    .irr_o    (s_irr),
    .isr_o    (s_isr),
    .valid_o  (s_valid),
    .lvl_o    (s_lvl),
    .low_o    (s_low_unused)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_M_CMD:  rdata_o = DW'(m_irr);
      ADDR_M_MASK: rdata_o = DW'(m_mask);
      ADDR_S_CMD:  rdata_o = DW'(s_irr);
      ADDR_S_MASK: rdata_o = DW'(s_mask);
      default:     rdata_o = '0;
    endcase
  end

  always_comb begin
    if (!m_valid)     vector_o = VW'(m_low);   // spurious code
    else if (casc_win) vector_o = VW'(N) + VW'(s_lvl);
    else              vector_o = VW'(m_lvl);
  end

  assign int_o = m_valid;

  a_r5_cascade_marks_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && casc_win |=> m_isr[CASC_LVL] && (s_isr != '0));
  a_r8_spurious_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && !int_o && !wr_i |=> $stable(m_isr) && $stable(s_isr));
  a_r4_vector_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |-> vector_o < VW'(2 * N));
endmodule

// File: tb/test_pic_cascade.sv
module test_pic_cascade;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        inta = 1'b0;
  logic [7:0]  rdata, vector;
  logic        int_w;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  int mmask, smask, mirr, sirr, misr, sisr, mlow, slow;

  always #5 clk = ~clk;

  pic_cascade i_pic_cascade (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .inta_i(inta), .vector_o(vector), .int_o(int_w)
  );

  function automatic int resolve(int pend, int isr, int low);
    for (int r = 0; r < 8; r++) begin
      int l = (low + 1 + r) % 8;
      if (((isr >> l) & 1) != 0) return -1;
      if (((pend >> l) & 1) != 0) return l;
    end
    return -1;
  endfunction

  function automatic int s_win();
    return resolve(sirr & ~smask & 255, sisr, slow);
  endfunction

  function automatic int m_view();
    return (mirr & ~4) | ((s_win() >= 0) ? 4 : 0);
  endfunction

  function automatic int m_win();
    return resolve(m_view() & ~mmask & 255, misr, mlow);
  endfunction

  function automatic int exp_vec();
    int w = m_win();
    if (w < 0) return mlow;
    if (w == 2) return 8 + s_win();
    return w;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      32'h20: return m_view();
      32'h21: return mmask;
      32'hA0: return sirr;
      32'hA1: return smask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmask = 255; smask = 255; mirr = 0; sirr = 0;
      misr = 0; sisr = 0; mlow = 7; slow = 7;
    end else begin
      int mw, sw, mclr, sclr, mset, sset, madd, sadd;
      mw = m_win(); sw = s_win();
      mclr = 0; sclr = 0; mset = 0; sset = 0; madd = 0; sadd = 0;
      if (inta && mw >= 0) begin
        mset = 1 << mw;
        if (mw == 2) begin sset = 1 << sw; sclr = 1 << sw; end
        else mclr = 1 << mw;
      end
      if (wr && wdata[7:5] == 3'b111 && addr == 8'h20) begin
        madd = 1 << wdata[2:0]; mlow = wdata[2:0];
      end
      if (wr && wdata[7:5] == 3'b111 && addr == 8'hA0) begin
        sadd = 1 << wdata[2:0]; slow = wdata[2:0];
      end
      misr = (misr & ~madd) | mset;
      sisr = (sisr & ~sadd) | sset;
      mirr = (mirr | irq[7:0]) & ~mclr & ~4;
      sirr = (sirr | irq[15:8]) & ~sclr;
      if (wr && addr == 8'h21) mmask = wdata;
      if (wr && addr == 8'hA1) smask = wdata;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 int_o", int_w, (m_win() >= 0) ? 1 : 0);
      chk("R2 R3 rdata", rdata, exp_rd(addr));
      if (inta) chk("R4 R8 vector", vector, exp_vec());
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #2;
    wr = 1'b0; addr = 8'h00;
  endtask

  task automatic rd_chk(logic [7:0] a, int exp, string tag);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    @(posedge clk); #2;
    addr = 8'h00;
  endtask

  task automatic ack_chk(int exp, string tag);
    @(posedge clk); #2;
    inta = 1'b1;
    @(negedge clk);
    chk(tag, vector, exp);
    @(posedge clk); #2;
    inta = 1'b0;
  endtask

  task automatic int_chk(int exp, string tag);
    @(negedge clk);
    chk(tag, int_w, exp);
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; irq = '0; inta = 1'b0; wr = 1'b0; addr = '0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    rd_chk(8'h21, 8'hFF, "R1 primary mask");
    rd_chk(8'hA1, 8'hFF, "R1 secondary mask");
    int_chk(0, "R1 int_o");

    irq = 16'h0028;
    rd_chk(8'h20, 8'h28, "R2 R3 masked lines latch");
    int_chk(0, "R2 masked no int");
    wr_reg(8'h21, 8'h00);
    int_chk(1, "R2 unmask raises int");
    ack_chk(3, "R4 fixed priority");
    rd_chk(8'h20, 8'h28, "R9 held line relatched");
    int_chk(0, "R6 lower rank blocked");
    wr_reg(8'h20, 8'hE3);
    ack_chk(5, "R7 rotated order");
    wr_reg(8'h20, 8'hE5);
    ack_chk(3, "R7 second rotation");
    wr_reg(8'h20, 8'hE3);

    do_reset();
    ack_chk(7, "R8 spurious code");
    wr_reg(8'h20, 8'hE4);
    ack_chk(4, "R8 spurious follows rotation");
    wr_reg(8'h20, 8'h64);
    ack_chk(4, "R7 other command ignored");
    irq = 16'h0040;
    @(posedge clk); #2 irq = '0;
    rd_chk(8'h20, 8'h40, "R9 latch holds after line falls");

    do_reset();
    wr_reg(8'h21, 8'h00);
    wr_reg(8'hA1, 8'h00);
    irq = 16'h0004;
    int_chk(0, "R10 line 2 ignored");
    rd_chk(8'h20, 8'h00, "R10 line 2 not latched");
    irq = 16'h0300;
    rd_chk(8'h20, 8'h04, "R3 cascade bit");
    ack_chk(8, "R4 R5 secondary vector");
    int_chk(0, "R6 cascade in service");
    wr_reg(8'hA0, 8'hE0);
    int_chk(0, "R6 primary level 2 blocks");
    irq = 16'h0302;
    wr_reg(8'h20, 8'hE2);
    ack_chk(1, "R4 primary beats cascade");
    wr_reg(8'h20, 8'hE1);
    ack_chk(9, "R5 secondary after rotation");

    for (int i = 0; i < 600; i++) begin
      int op;
      @(posedge clk); #2;
      op = $urandom_range(0, 9);
      irq = 16'($urandom) & 16'($urandom);
      inta = (op < 3);
      wr = 1'b0;
      addr = 8'($urandom_range(0, 3) == 0 ? 8'h21 : 8'hA0);
      wdata = 8'($urandom);
      if (op == 3 || op == 4) begin wr = 1'b1; addr = 8'h20; wdata = 8'hE0 | 8'($urandom_range(0, 7)); end
      if (op == 5) begin wr = 1'b1; addr = 8'hA0; wdata = 8'hE0 | 8'($urandom_range(0, 7)); end
      if (op == 6) begin wr = 1'b1; addr = ($urandom_range(0, 1) == 0) ? 8'h21 : 8'hA1; wdata = 8'($urandom) & 8'($urandom); end
    end
    @(posedge clk); #2;
    inta = 1'b0; wr = 1'b0; irq = '0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule